// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Event Routing

This block is an 8-pin general-purpose I/O port behind a small byte-wide register interface. Software drives output levels, reads back synchronized input levels and arms each pin to raise an event. An event fires either on a chosen level or on a chosen edge. Every event is latched as a sticky status bit. Software clears a status bit by writing 1 to it.

The per-pin setup is not mapped directly. Software first writes a pin index into a select register. It then reaches that pin's two configuration registers and its routing register through a three-address window. The routing register steers the pin's pending event to any mix of four system notification outputs: an interrupt request, a system-management interrupt, a system-control interrupt and a power-button pulse. A pending event reaches an output only when the pin's enable bit is set and its routing bit for that output is set. The outputs are the OR of these terms over all pins.

Addresses on the 3-bit register bus map as follows. 0 is data out. 1 is data in and is read-only. 2 is event enable. 3 is event status and clears on write-1. 4 is the pin select. 5 is configuration A of the selected pin. 6 is configuration B of the selected pin. 7 is the routing register of the selected pin. Writes take effect at the clock edge. Reads are combinational.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset every register reads 0, every output enable is low, and all four notification outputs are low.
- R2: Configuration A bit 0 of pin n drives `pin_oe_o[n]`. `pin_o` always shows the data-out register, and that register keeps its value while the output enable is low.
- R3: Address 1 returns the pin inputs after a two-flop synchronizer, so a change becomes visible on the second clock edge. Writes to address 1 change nothing.
- R4: Address 4 holds a 3-bit pin index. Addresses 5, 6 and 7 read and write only the selected pin's configuration A (3 bits), configuration B (8 bits) and routing register (4 bits). Unused upper bits read 0.
- R5: When configuration A bit 2 is 0, the event is edge-triggered. Bit 1 = 1 selects a rising edge and bit 1 = 0 selects a falling edge. The status bit sets on the third clock edge after the pin changes.
- R6: When configuration A bit 2 is 1, the event is level-triggered. The status bit sets on every edge at which the synchronized pin equals configuration A bit 1.
- R7: Status bits are sticky and are cleared by writing 1 to address 3. If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R8: Routing bit 0 steers to `irq_o`, bit 1 to `smi_o` and bit 2 to `sci_o`. Each output is the OR over all pins of status AND enable AND that routing bit.
- R9: Routing bit 3 steers to `pwrbtn_o`. That output is a single-cycle pulse in the cycle its OR-term rises.
- R10: Status latches whether or not the enable bit is set. Enabling a pin whose status is already set raises its routed outputs immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin output levels |
| pin_oe_o | output | 8 | Pin output enables (low = tri-stated) |
| irq_o | output | 1 | Interrupt request |
| smi_o | output | 1 | System-management interrupt |
| sci_o | output | 1 | System-control interrupt |
| pwrbtn_o | output | 1 | Power-button pulse |

## Verification
The conflict that matters is a write-1 clear of the status register landing in the same cycle as a new event on that bit. The bench provokes it by holding a pin in its armed level in level mode while software clears that bit. The read that follows must still show the bit set. An edge-mode bit cleared with no new event must read 0 afterwards. A cycle-accurate behavioural model in the bench checks every status bit, read value and notification output on each clock. So the same-cycle outcome is checked both by the directed read and by the per-clock comparison.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int ADDR_W   = 3;
  localparam int CFGA_W   = 3;
  localparam int CFGA_OE  = 0;
  localparam int CFGA_POL = 1;
  localparam int CFGA_LVL = 2;
  localparam int NTGT     = 4;
  localparam int TGT_IRQ  = 0;
  localparam int TGT_SMI  = 1;
  localparam int TGT_SCI  = 2;
  localparam int TGT_PWR  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DOUT  = 3'd0,
    A_DIN   = 3'd1,
    A_EVEN  = 3'd2,
    A_EVST  = 3'd3,
    A_SEL   = 3'd4,
    A_CFGA  = 3'd5,
    A_CFGB  = 3'd6,
    A_ROUTE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = d_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int NPIN = 8
) (
  input  logic [NPIN-1:0] cur_i,
  input  logic [NPIN-1:0] prev_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] lvl_i,
  output logic [NPIN-1:0] hit_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = cur_i[g] & ~prev_i[g];
    assign fall     = ~cur_i[g] & prev_i[g];
    assign edge_hit = pol_i[g] ? rise : fall;
    assign lvl_hit  = ~(cur_i[g] ^ pol_i[g]);
    assign hit_o[g] = lvl_i[g] ? lvl_hit : edge_hit;
  end
endmodule

// File: rtl/gpio_evt_route.sv
module gpio_evt_route #(
  parameter int NPIN = 8,
  parameter int NTGT = 4
) (
  input  logic [NPIN-1:0]      pend_i,
  input  logic [NPIN*NTGT-1:0] route_i,
  output logic [NTGT-1:0]      tgt_o
);
  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    logic [NPIN-1:0] term;
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign term[p] = pend_i[p] & route_i[p*NTGT+t];
    end
    assign tgt_o[t] = |term;
  end
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_evt_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NPIN-1:0]   reg_wdata_i,
  output logic [NPIN-1:0]   reg_rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o,
  output logic              smi_o,
  output logic              sci_o,
  output logic              pwrbtn_o
);
  localparam int SEL_W  = $clog2(NPIN);
  localparam int CFGB_W = NPIN;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // register state
  logic [NPIN-1:0]              dout_q, dout_d;
  logic [NPIN-1:0]              en_q, en_d;
  logic [NPIN-1:0]              st_q, st_d;
  logic [SEL_W-1:0]             sel_q, sel_d;
  logic [NPIN-1:0][CFGA_W-1:0]  cfga_q, cfga_d;
  logic [NPIN-1:0][CFGB_W-1:0]  cfgb_q, cfgb_d;
  logic [NPIN-1:0][NTGT-1:0]    rt_q, rt_d;
  logic                         pwr_prev_q, pwr_prev_d;

  logic [NPIN-1:0] clr;
  logic [NPIN-1:0] din_sync, din_prev;
  logic [NPIN-1:0] pol, lvl, oe, hit, pend;
  logic [NTGT-1:0] tgt;

  gpio_evt_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (pin_i),
    .sync_o (din_sync),
    .prev_o (din_prev)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_cfg
    assign oe[g]  = cfga_q[g][CFGA_OE];
    assign pol[g] = cfga_q[g][CFGA_POL];
    assign lvl[g] = cfga_q[g][CFGA_LVL];
  end

  gpio_evt_detect #(.NPIN(NPIN)) u_det (
    .cur_i  (din_sync),
    .prev_i (din_prev),
    .pol_i  (pol),
    .lvl_i  (lvl),
    .hit_o  (hit)
  );

  assign pend = st_q & en_q;

  gpio_evt_route #(.NPIN(NPIN), .NTGT(NTGT)) u_route (
    .pend_i  (pend),
    .route_i (rt_q),
    .tgt_o   (tgt)
  );

  // next-state logic
  always_comb begin
    dout_d = dout_q;
    en_d   = en_q;
    sel_d  = sel_q;
    cfga_d = cfga_q;
    cfgb_d = cfgb_q;
    rt_d   = rt_q;
    clr    = '0;
    if (reg_we_i) begin
      case (reg_addr_i)
        A_DOUT:  dout_d = reg_wdata_i;
        A_EVEN:  en_d   = reg_wdata_i;
        A_EVST:  clr    = reg_wdata_i;
        A_SEL:   sel_d  = reg_wdata_i[SEL_W-1:0];
        A_CFGA:  cfga_d[sel_q] = reg_wdata_i[CFGA_W-1:0];
        A_CFGB:  cfgb_d[sel_q] = reg_wdata_i;
        A_ROUTE: rt_d[sel_q]   = reg_wdata_i[NTGT-1:0];
        default: ;
      endcase
    end
    st_d       = (st_q & ~clr) | hit;
    pwr_prev_d = tgt[TGT_PWR];
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dout_q     <= '0;
      en_q       <= '0;
      st_q       <= '0;
      sel_q      <= '0;
      cfga_q     <= '0;
      cfgb_q     <= '0;
      rt_q       <= '0;
      pwr_prev_q <= 1'b0;
    end else begin
      dout_q     <= dout_d;
      en_q       <= en_d;
      st_q       <= st_d;
      sel_q      <= sel_d;
      cfga_q     <= cfga_d;
      cfgb_q     <= cfgb_d;
      rt_q       <= rt_d;
      pwr_prev_q <= pwr_prev_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DOUT:  reg_rdata_o = dout_q;
      A_DIN:   reg_rdata_o = din_sync;
      A_EVEN:  reg_rdata_o = en_q;
      A_EVST:  reg_rdata_o = st_q;
      A_SEL:   reg_rdata_o[SEL_W-1:0]  = sel_q;
      A_CFGA:  reg_rdata_o[CFGA_W-1:0] = cfga_q[sel_q];
      A_CFGB:  reg_rdata_o = cfgb_q[sel_q];
      A_ROUTE: reg_rdata_o[NTGT-1:0]   = rt_q[sel_q];
      default: reg_rdata_o = '0;
    endcase
  end

  assign pin_o    = dout_q;
  assign pin_oe_o = oe;
  assign irq_o    = tgt[TGT_IRQ];
  assign smi_o    = tgt[TGT_SMI];
  assign sci_o    = tgt[TGT_SCI];
  assign pwrbtn_o = tgt[TGT_PWR] & ~pwr_prev_q;
endmodule

// File: rtl/gpio_evt_port_chk.sv
module gpio_evt_port_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [NPIN-1:0] st,
  input logic [NPIN-1:0] en,
  input logic [NPIN-1:0] pin_out,
  input logic            irq,
  input logic            smi,
  input logic            sci,
  input logic            pwr
);
  // R7: without a clear write, no status bit falls
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd3) |=> (($past(st) & ~st) == '0));

  // R2: pin outputs move only on a data-out write
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd0) |=> $stable(pin_out));

  // R8: a level notification needs some enabled pending status
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || smi || sci) |-> (|(st & en)));

  // R9: the power-button output never lasts two cycles
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr |=> !pwr);

  // R10: with every enable clear, nothing is notified
  p_noen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !(irq || smi || sci || pwr));
endmodule

bind gpio_evt_port gpio_evt_port_chk #(.NPIN(NPIN)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_n),
  .reg_we   (reg_we_i),
  .reg_addr (reg_addr_i),
  .st       (st_q),
  .en       (en_q),
  .pin_out  (pin_o),
  .irq      (irq_o),
  .smi      (smi_o),
  .sci      (sci_o),
  .pwr      (pwrbtn_o)
);

// File: tb/gpio_evt_port_bench.sv
module gpio_evt_port_bench;
  logic       clk;
  logic       rst_n;
  logic       we;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic       irq, smi, sci, pwr;

  int checks = 0;
  int errors = 0;
  logic chk_on = 1'b0;

  gpio_evt_port u_gpio_evt_port (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pin_i       (pin_in),
    .pin_o       (pin_out),
    .pin_oe_o    (pin_oe),
    .irq_o       (irq),
    .smi_o       (smi),
    .sci_o       (sci),
    .pwrbtn_o    (pwr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  logic [7:0] m_do, m_en, m_st, m_s1, m_s2, m_p;
  int         m_sel;
  logic [2:0] m_ca [8];
  logic [7:0] m_cb [8];
  logic [3:0] m_rt [8];
  logic [1:0] m_rel;
  logic       m_pbp;

  function automatic logic [3:0] m_tgt();
    logic [3:0] r = '0;
    for (int i = 0; i < 8; i++)
      if (m_st[i] && m_en[i]) r = r | m_rt[i];
    return r;
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_do;
      3'd1: return m_s2;
      3'd2: return m_en;
      3'd3: return m_st;
      3'd4: return 8'(m_sel);
      3'd5: return {5'b0, m_ca[m_sel]};
      3'd6: return m_cb[m_sel];
      default: return {4'b0, m_rt[m_sel]};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0] nst;
    logic [3:0] tg;
    logic       h;
    if (!rst_n) begin
      m_do = '0; m_en = '0; m_st = '0; m_s1 = '0; m_s2 = '0; m_p = '0;
      m_sel = 0; m_rel = '0; m_pbp = 1'b0;
      for (int i = 0; i < 8; i++) begin
        m_ca[i] = '0; m_cb[i] = '0; m_rt[i] = '0;
      end
    end else begin
      if (m_rel[1]) begin
        tg  = m_tgt();
        nst = m_st;
        if (we && addr == 3'd3) nst = nst & ~wdata;
        for (int i = 0; i < 8; i++) begin
          if (m_ca[i][2]) h = (m_s2[i] == m_ca[i][1]);
          else if (m_ca[i][1]) h = m_s2[i] && !m_p[i];
          else h = !m_s2[i] && m_p[i];
          if (h) nst[i] = 1'b1;
        end
        if (we) begin
          case (addr)
            3'd0: m_do <= wdata;
            3'd2: m_en <= wdata;
            3'd4: m_sel <= int'(wdata[2:0]);
            3'd5: m_ca[m_sel] <= wdata[2:0];
            3'd6: m_cb[m_sel] <= wdata;
            3'd7: m_rt[m_sel] <= wdata[3:0];
            default: ;
          endcase
        end
        m_st  <= nst;
        m_p   <= m_s2;
        m_s2  <= m_s1;
        m_s1  <= pin_in;
        m_pbp <= tg[3];
      end
      m_rel <= {m_rel[0], 1'b1};
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (chk_on) begin : cmp
      logic [7:0] oe_e;
      logic [3:0] tg;
      for (int i = 0; i < 8; i++) oe_e[i] = m_ca[i][0];
      tg = m_tgt();
      chk("R2 pin_o", pin_out, m_do);
      chk("R2 pin_oe_o", pin_oe, oe_e);
      chk("R4 read data", rdata, m_read(addr));
      chk("R8 irq/smi/sci", {5'b0, sci, smi, irq}, {5'b0, tg[2:0]});
      chk("R9 pwrbtn", {7'b0, pwr}, {7'b0, tg[3] & ~m_pbp});
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] mask, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata & mask, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int pulses;
    we = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 8'hFF, 8'h00, "R1 reset read");
    chk("R1 oe after reset", pin_oe, 8'h00);
    chk("R1 outputs after reset", {4'b0, irq, smi, sci, pwr}, 8'h00);

    // R2: output enable and retained data out
    wr(3'd4, 8'd2);
    wr(3'd5, 8'h01);
    wr(3'd0, 8'hA5);
    chk("R2 oe pin2", pin_oe, 8'h04);
    chk("R2 data out", pin_out, 8'hA5);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h5A);
    chk("R2 oe disabled", pin_oe, 8'h00);
    wr(3'd5, 8'h01);
    chk("R2 retained data", pin_out, 8'h5A);

    // R4: indirect window
    wr(3'd4, 8'hF9);            // index 1 (upper bits dropped)
    rd(3'd4, 8'hFF, 8'h01, "R4 select width");
    wr(3'd6, 8'h3C);
    wr(3'd7, 8'hFF);
    wr(3'd5, 8'hFE);
    rd(3'd7, 8'hFF, 8'h0F, "R4 route read");
    rd(3'd5, 8'hFF, 8'h06, "R4 cfg A read");
    wr(3'd4, 8'd2);
    rd(3'd6, 8'hFF, 8'h00, "R4 other pin cfg B");
    rd(3'd5, 8'hFF, 8'h01, "R4 other pin cfg A");
    wr(3'd4, 8'd1);
    rd(3'd6, 8'hFF, 8'h3C, "R4 cfg B read");
    wr(3'd5, 8'h00);           // pin 1 back to falling edge, never enabled

    // R3: synchronized data in, read-only
    @(negedge clk); pin_in = 8'h81;
    rd(3'd1, 8'hFF, 8'h00, "R3 one edge");
    rd(3'd1, 8'hFF, 8'h81, "R3 two edges");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'hFF, 8'h81, "R3 write ignored");

    // R5: rising edge on pin 5 routed to irq
    wr(3'd4, 8'd5);
    wr(3'd5, 8'h02);
    wr(3'd7, 8'h01);
    wr(3'd2, 8'h20);
    wr(3'd3, 8'hFF);
    @(negedge clk); pin_in = 8'hA1;
    rd(3'd3, 8'h20, 8'h00, "R5 edge 1");
    rd(3'd3, 8'h20, 8'h00, "R5 edge 2");
    rd(3'd3, 8'h20, 8'h20, "R5 edge 3 sets");
    chk("R8 irq raised", {7'b0, irq}, 8'h01);
    @(negedge clk); pin_in = 8'h81;
    repeat (4) @(negedge clk);
    rd(3'd3, 8'h20, 8'h20, "R7 sticky after pin drop");
    wr(3'd3, 8'h20);
    rd(3'd3, 8'h20, 8'h00, "R7 clear");
    chk("R8 irq dropped", {7'b0, irq}, 8'h00);

    // R6 / R7: level low on pin 3, clear collides with set
    wr(3'd4, 8'd3);
    wr(3'd5, 8'h04);
    rd(3'd3, 8'h08, 8'h08, "R6 level sets");
    wr(3'd3, 8'h08);
    rd(3'd3, 8'h08, 8'h08, "R7 set wins over clear");
    @(negedge clk); pin_in = 8'h89;
    repeat (3) @(negedge clk);
    wr(3'd3, 8'h08);
    rd(3'd3, 8'h08, 8'h00, "R6 level gone");

    // R9: power-button pulse from pin 6 rising
    wr(3'd4, 8'd6);
    wr(3'd5, 8'h02);
    wr(3'd7, 8'h08);
    wr(3'd2, 8'h60);
    pulses = 0;
    @(negedge clk); pin_in = 8'hC9;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      if (pwr) pulses++;
    end
    chk("R9 single pulse", 8'(pulses), 8'd1);

    // R10: latch with enable off, then enable pin 4 routed to smi
    wr(3'd4, 8'd4);
    wr(3'd5, 8'h02);
    wr(3'd7, 8'h02);
    @(negedge clk); pin_in = 8'hD9;
    repeat (4) @(negedge clk);
    rd(3'd3, 8'h10, 8'h10, "R10 status without enable");
    chk("R10 smi gated", {7'b0, smi}, 8'h00);
    wr(3'd2, 8'h70);
    chk("R10 smi after enable", {7'b0, smi}, 8'h01);
    chk("R8 sci untouched", {7'b0, sci}, 8'h00);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule